// File: doc/BRIEF.md
# Handshake-Driven Memory Word Read Controller

The controller turns each request on a passive four-phase count channel into one word read from a memory macro. The macro has no handshake of its own. A count value in the range 1 to NUM_CH becomes a byte address, which is the count times ADDR_STEP. The controller drives that address and raises an address request. It waits for a settle acknowledge, which it builds internally by passing the request through a SETUP_CYC-cycle delay line. It then runs a four-phase sense-enable handshake. In that handshake the sense acknowledge is the AND of sense-enable and the memory's data-valid flag, and the data is the memory's word output.

The word is latched when the sense acknowledge is seen high. Sense-enable then drops, and the address request returns to zero. The word is then pushed on the output channel selected by the count. Only after that push has completed its return to zero is the count acknowledged. A count outside the mapped range gets no memory access and no push; it is simply acknowledged. The model is synchronous: the address setup gap and the memory access time are whole clock cycles.

Top module: `mem_read_ctrl`

## Requirements
- R1: While rst_ni is low, cnt_ack_o, addr_req_o, se_o and every bit of rd_req_o are 0.
- R2: A count value k with 1 <= k <= NUM_CH drives mem_addr_o to k*ADDR_STEP (4, 8, 12, 16 for k = 1..4 with the defaults) before sense-enable rises.
- R3: A count value of 0 or above NUM_CH produces no sense-enable pulse and no push on any output channel, and it is still acknowledged.
- R4: se_o rises only after addr_req_o has been high for at least SETUP_CYC cycles.
- R5: mem_addr_o does not change in any cycle in which se_o, or the sense acknowledge (se_o AND dv_i), was high in the previous cycle.
- R6: Each in-range count yields exactly one 0-to-1 transition of se_o, and se_o is low between reads.
- R7: The word present on dout_i when the sense acknowledge is first seen is pushed on output channel k-1, on rd_req_o[k-1] with data rd_data_o. No other channel's request rises.
- R8: On an output channel, rd_data_o is stable while the request is high. The request falls only after its acknowledge, and cnt_ack_o rises only once that channel's request and acknowledge are both low.
- R9: cnt_ack_o stays high for as long as cnt_req_i stays high, and falls after cnt_req_i falls.
- R10: se_o stays high until dv_i has been seen high, whatever the memory's access delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_req_i | input | 1 | Count channel request |
| cnt_val_i | input | CNT_W | Count channel data |
| cnt_ack_o | output | 1 | Count channel acknowledge |
| mem_addr_o | output | ADDR_W | Byte address to the memory |
| addr_req_o | output | 1 | Address request, looped back internally as the settle acknowledge |
| se_o | output | 1 | Sense-enable (read request to the memory) |
| dv_i | input | 1 | Memory data-valid |
| dout_i | input | DATA_W | Memory word output |
| rd_req_o | output | NUM_CH | Per-channel push request |
| rd_ack_i | input | NUM_CH | Per-channel push acknowledge |
| rd_data_o | output | DATA_W | Pushed word, shared by all channels |

## Verification
The bench builds the controller with SETUP_CYC = 3, NUM_CH = 4 and a 4-bit count. A 4-bit count reaches the unmapped values 0 and 5 to 15, alongside every mapped channel. The setup gap of three cycles makes a premature sense-enable visible as a counted shortfall in the request age. The memory model draws an access delay of 0 to 7 cycles for each read, and the push responders draw acknowledge delays of 0 to 4 cycles. Sense acknowledges can therefore arrive on the first cycle or long after, and push completion can land in any order relative to count release.

// File: rtl/mem_read_pkg.sv
package mem_read_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SENSE,
    ST_REL,
    ST_PUSH,
    ST_PUSH_RTZ,
    ST_CACK
  } rd_state_e;

endpackage

// File: rtl/mrc_addr_map.sv
module mrc_addr_map #(
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 12,
  parameter int NUM_CH    = 4,
  parameter int ADDR_STEP = 4
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NUM_CH-1:0] sel_o
);

  localparam int PROD_W = CNT_W + ADDR_W;

  logic [PROD_W-1:0] prod;

  assign hit_o = (cnt_i != '0) && (PROD_W'(cnt_i) <= PROD_W'(NUM_CH));
  assign prod  = PROD_W'(cnt_i) * PROD_W'(ADDR_STEP);
  assign addr_o = prod[ADDR_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign sel_o[g] = (PROD_W'(cnt_i) == PROD_W'(g + 1));
  end

endmodule

// File: rtl/mrc_settle_dly.sv
// Loop-back delay standing in for the memory's missing address acknowledge.
module mrc_settle_dly #(
  parameter int DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ack_o
);

  if (DLY <= 1) begin : g_one
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= req_i;
    end
    assign ack_o = q;
  end else begin : g_line
    logic [DLY-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '0;
      else         sh <= {sh[DLY-2:0], req_i};
    end
    assign ack_o = sh[DLY-1];
  end

endmodule

// File: rtl/mrc_seq.sv
module mrc_seq
  import mem_read_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_req_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] map_addr_i,
  input  logic [NUM_CH-1:0] map_sel_i,
  input  logic              settled_i,
  input  logic              dv_i,
  input  logic [DATA_W-1:0] dout_i,
  input  logic              push_ack_i,
  output logic              cnt_ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_req_o,
  output logic              se_o,
  output logic [DATA_W-1:0] word_o,
  output logic [NUM_CH-1:0] sel_o,
  output logic              push_o
);

  rd_state_e st_q;
  logic      sense_ack;

  assign sense_ack = se_o & dv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_ack_o  <= 1'b0;
      addr_o     <= '0;
      addr_req_o <= 1'b0;
      se_o       <= 1'b0;
      word_o     <= '0;
      sel_o      <= '0;
      push_o     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cnt_req_i) begin
          if (hit_i) begin
            addr_o     <= map_addr_i;
            sel_o      <= map_sel_i;
            addr_req_o <= 1'b1;
            st_q       <= ST_ADDR;
          end else begin
            cnt_ack_o  <= 1'b1;
            st_q       <= ST_CACK;
          end
        end
        ST_ADDR: if (settled_i) begin
          se_o <= 1'b1;
          st_q <= ST_SENSE;
        end
        ST_SENSE: if (sense_ack) begin
          word_o <= dout_i;
          se_o   <= 1'b0;
          st_q   <= ST_REL;
        end
        // sense ack is low once se_o is low; address channel returns to zero
        ST_REL: begin
          addr_req_o <= 1'b0;
          if (!addr_req_o && !settled_i) begin
            push_o <= 1'b1;
            st_q   <= ST_PUSH;
          end
        end
        ST_PUSH: if (push_ack_i) begin
          push_o <= 1'b0;
          st_q   <= ST_PUSH_RTZ;
        end
        ST_PUSH_RTZ: if (!push_ack_i) begin
          cnt_ack_o <= 1'b1;
          st_q      <= ST_CACK;
        end
        ST_CACK: if (!cnt_req_i) begin
          cnt_ack_o <= 1'b0;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mrc_push_demux.sv
module mrc_push_demux #(
  parameter int NUM_CH = 4
) (
  input  logic              push_i,
  input  logic [NUM_CH-1:0] sel_i,
  input  logic [NUM_CH-1:0] rd_ack_i,
  output logic [NUM_CH-1:0] rd_req_o,
  output logic              ack_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign rd_req_o[g] = push_i & sel_i[g];
  end

  assign ack_o = |(rd_ack_i & sel_i);

endmodule

// File: rtl/mem_read_ctrl.sv
module mem_read_ctrl #(
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int ADDR_STEP = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_req_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  output logic              cnt_ack_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              addr_req_o,
  output logic              se_o,
  input  logic              dv_i,
  input  logic [DATA_W-1:0] dout_i,
  output logic [NUM_CH-1:0] rd_req_o,
  input  logic [NUM_CH-1:0] rd_ack_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              hit;
  logic [ADDR_W-1:0] map_addr;
  logic [NUM_CH-1:0] map_sel;
  logic [NUM_CH-1:0] sel_q;
  logic              settled;
  logic              push;
  logic              push_ack;

  mrc_addr_map #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .ADDR_STEP(ADDR_STEP)
  ) u_map (
    .cnt_i (cnt_val_i),
    .hit_o (hit),
    .addr_o(map_addr),
    .sel_o (map_sel)
  );

  mrc_settle_dly #(.DLY(SETUP_CYC)) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (addr_req_o),
    .ack_o (settled)
  );

  mrc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_req_i (cnt_req_i),
    .hit_i     (hit),
    .map_addr_i(map_addr),
    .map_sel_i (map_sel),
    .settled_i (settled),
    .dv_i      (dv_i),
    .dout_i    (dout_i),
    .push_ack_i(push_ack),
    .cnt_ack_o (cnt_ack_o),
    .addr_o    (mem_addr_o),
    .addr_req_o(addr_req_o),
    .se_o      (se_o),
    .word_o    (rd_data_o),
    .sel_o     (sel_q),
    .push_o    (push)
  );

  mrc_push_demux #(.NUM_CH(NUM_CH)) u_demux (
    .push_i  (push),
    .sel_i   (sel_q),
    .rd_ack_i(rd_ack_i),
    .rd_req_o(rd_req_o),
    .ack_o   (push_ack)
  );

endmodule

// File: rtl/mem_read_ctrl_chk.sv
module mem_read_ctrl_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int SETUP_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_req_i,
  input logic              cnt_ack_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              addr_req_o,
  input logic              se_o,
  input logic              dv_i,
  input logic [NUM_CH-1:0] rd_req_o,
  input logic [DATA_W-1:0] rd_data_o
);

  localparam int AGE_W = $clog2(SETUP_CYC + 2) + 1;

  logic [AGE_W-1:0] req_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        req_age <= '0;
    else if (!addr_req_o)               req_age <= '0;
    else if (req_age < AGE_W'(SETUP_CYC)) req_age <= req_age + 1'b1;
  end

  a_r4_setup_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(se_o) |-> (addr_req_o && req_age >= AGE_W'(SETUP_CYC)));

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(se_o) || $past(se_o && dv_i)) |-> $stable(mem_addr_o));

  a_r6_sense_in_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se_o |-> addr_req_o);

  a_r7_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_req_o));

  a_r8_push_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rd_req_o) && $past(|rd_req_o)) |-> $stable(rd_data_o));

  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ack_o |-> (rd_req_o == '0 && !se_o));

  a_r9_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ack_o && cnt_req_i) |=> cnt_ack_o);

  a_r10_wait_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (se_o && !dv_i) |=> se_o);

endmodule

bind mem_read_ctrl mem_read_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .SETUP_CYC(SETUP_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_req_i (cnt_req_i),
  .cnt_ack_o (cnt_ack_o),
  .mem_addr_o(mem_addr_o),
  .addr_req_o(addr_req_o),
  .se_o      (se_o),
  .dv_i      (dv_i),
  .rd_req_o  (rd_req_o),
  .rd_data_o (rd_data_o)
);

// File: tb/mem_read_ctrl_bench.sv
module mem_read_ctrl_bench;

  localparam int CNT_W = 4, ADDR_W = 12, DATA_W = 32, NUM_CH = 4;
  localparam int ADDR_STEP = 4, SETUP_CYC = 3, ACC_MAX = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cnt_req_i = 1'b0;
  logic [CNT_W-1:0]  cnt_val_i = '0;
  logic              cnt_ack_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              addr_req_o;
  logic              se_o;
  logic              dv_i = 1'b0;
  logic [DATA_W-1:0] dout_i = '0;
  logic [NUM_CH-1:0] rd_req_o;
  logic [NUM_CH-1:0] rd_ack_i = '0;
  logic [DATA_W-1:0] rd_data_o;

  always #5 clk_i = ~clk_i;

  mem_read_ctrl #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
    .ADDR_STEP(ADDR_STEP), .SETUP_CYC(SETUP_CYC)
  ) u_mem_read_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int          se_rises = 0;
  logic [ADDR_W-1:0] addr_at_rise = '0;
  int          v_hold = 0, v_setup = 0, v_early = 0, v_pdata = 0;
  int          push_cnt [NUM_CH];
  logic [DATA_W-1:0] push_dat [NUM_CH];

  function automatic logic [DATA_W-1:0] mem_word(logic [ADDR_W-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: access delay drawn per read, data-valid drops with sense-enable
  initial begin
    int acc_left;
    logic [ADDR_W-1:0] last_a;
    acc_left = 0;
    last_a = '0;
    forever begin
      @(posedge clk_i); #2;
      if (!rst_ni) begin
        dv_i = 1'b0;
      end else begin
        if (mem_addr_o != last_a) dout_i = 32'hFFFF_FFFF;
        last_a = mem_addr_o;
        if (se_o) begin
          if (!dv_i) begin
            if (acc_left == 0) begin
              dv_i = 1'b1;
              dout_i = mem_word(mem_addr_o);
            end else acc_left--;
          end
        end else begin
          dv_i = 1'b0;
          acc_left = $urandom_range(0, ACC_MAX);
        end
      end
    end
  end

  // push responders
  initial begin
    int dly [NUM_CH];
    for (int i = 0; i < NUM_CH; i++) begin
      dly[i] = 0; push_cnt[i] = 0; push_dat[i] = '0;
    end
    forever begin
      @(posedge clk_i); #2;
      for (int i = 0; i < NUM_CH; i++) begin
        if (rd_req_o[i] && !rd_ack_i[i]) begin
          if (dly[i] == 0) begin
            rd_ack_i[i] = 1'b1;
            push_cnt[i]++;
            push_dat[i] = rd_data_o;
          end else dly[i]--;
        end else if (!rd_req_o[i] && rd_ack_i[i]) begin
          rd_ack_i[i] = 1'b0;
          dly[i] = $urandom_range(0, 4);
        end
      end
    end
  end

  // port monitor
  initial begin
    logic prev_se, prev_dv, prev_push;
    logic [ADDR_W-1:0] prev_a;
    logic [DATA_W-1:0] prev_d;
    int age;
    prev_se = 0; prev_dv = 0; prev_push = 0; prev_a = '0; prev_d = '0; age = 0;
    forever begin
      @(posedge clk_i); #4;
      if (rst_ni) begin
        if (prev_se && mem_addr_o != prev_a) v_hold++;
        if (se_o && !prev_se) begin
          se_rises++;
          addr_at_rise = mem_addr_o;
          if (age < SETUP_CYC) v_setup++;
        end
        if (!se_o && prev_se && !prev_dv) v_early++;
        if (prev_push && (|rd_req_o) && rd_data_o != prev_d) v_pdata++;
        age = addr_req_o ? age + 1 : 0;
      end
      prev_se = se_o; prev_dv = dv_i; prev_a = mem_addr_o;
      prev_push = |rd_req_o; prev_d = rd_data_o;
    end
  end

  task automatic do_count(input int k);
    int s0, hold;
    int p0 [NUM_CH];
    bit valid;
    valid = (k >= 1 && k <= NUM_CH);
    s0 = se_rises;
    for (int i = 0; i < NUM_CH; i++) p0[i] = push_cnt[i];
    cnt_val_i = CNT_W'(k);
    cnt_req_i = 1'b1;
    do begin @(posedge clk_i); #4; end while (!cnt_ack_o);
    chk(rd_req_o == '0 && rd_ack_i == '0, "R8 ack after push rtz",
        {rd_req_o, rd_ack_i}, 0);
    hold = $urandom_range(0, 3);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk_i); #4;
      chk(cnt_ack_o, "R9 ack held", cnt_ack_o, 1);
    end
    cnt_req_i = 1'b0;
    do begin @(posedge clk_i); #4; end while (cnt_ack_o);
    chk(!cnt_ack_o, "R9 ack released", cnt_ack_o, 0);
    if (valid) begin
      chk(se_rises - s0 == 1, "R6 one sense pulse", se_rises - s0, 1);
      chk(addr_at_rise == ADDR_W'(k * ADDR_STEP), "R2 address map",
          addr_at_rise, k * ADDR_STEP);
      chk(!se_o, "R6 sense low between reads", se_o, 0);
    end else begin
      chk(se_rises == s0, "R3 no sense on unmapped count", se_rises - s0, 0);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      int exp_n;
      exp_n = (valid && i == k - 1) ? 1 : 0;
      chk(push_cnt[i] - p0[i] == exp_n, valid ? "R7 push channel" : "R3 no push",
          push_cnt[i] - p0[i], exp_n);
      if (exp_n == 1)
        chk(push_dat[i] == mem_word(ADDR_W'(k * ADDR_STEP)), "R7 pushed word",
            push_dat[i], mem_word(ADDR_W'(k * ADDR_STEP)));
    end
    repeat ($urandom_range(0, 2)) @(posedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    #4;
    chk(!cnt_ack_o && !addr_req_o && !se_o && rd_req_o == '0, "R1 reset outputs",
        {cnt_ack_o, addr_req_o, se_o, rd_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    // directed: every mapped channel, then unmapped extremes
    for (int k = 1; k <= NUM_CH; k++) do_count(k);
    do_count(0);
    do_count(NUM_CH + 1);
    do_count((1 << CNT_W) - 1);
    do_count(4); do_count(4); do_count(1);
    // random mix
    for (int n = 0; n < 60; n++) do_count($urandom_range(0, 7));
    chk(v_hold == 0, "R5 address stable under sense", v_hold, 0);
    chk(v_setup == 0, "R4 setup gap", v_setup, 0);
    chk(v_early == 0, "R10 sense held for valid", v_early, 0);
    chk(v_pdata == 0, "R8 push data stable", v_pdata, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule